// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block gathers up to 32 level-sensitive interrupt request lines and sends them to a processor core on two lines: a fast-interrupt line and a normal-interrupt line. Software puts every source in one of three classes through a small synchronous register bus. A source can be fast, it can be bound to one of 16 prioritized vector slots, or it can be left as plain non-vectored. Each source also has its own enable bit.

The fast line is the OR of all enabled fast-class sources. The normal line is the OR of every other enabled source. A fast handler that serves several sources reads a status word to see which of them are pending. A normal handler first reads the vector-address register. That register returns the handler address held by the lowest-numbered active slot. When no slot is active, it returns a shared default address, and the default handler then reads the normal-class status word to find the pending sources.

Both interrupt lines and every read value are combinational from the registered configuration and the current input levels. Configuration writes are captured on the clock edge.

Top module: `intr_vector_ctrl`

## Requirements
- R1: `fiq_o` is high exactly when some source is requesting, has its enable bit set (register 0x00) and has its class bit set to fast (register 0x01, 1 = fast).
- R2: Reading register 0x03 returns, bit per source, the sources that are requesting, enabled and fast-class.
- R3: There are 16 slots. The control register of slot k is at 0x10+k, with the source index in bits [5:0] and the slot enable in bit 7. The handler address of slot k is at 0x20+k. Any source index can go into any slot, and both registers read back what was written.
- R4: When more than one slot is active, the slot with the lowest number wins the vector-address read.
- R5: `irq_o` is high exactly when some source is requesting, enabled and not fast-class.
- R6: Reading register 0x05 returns the handler address of the winning active slot. When no slot is active, it returns the default address held at register 0x06.
- R7: Reading register 0x04 returns, bit per source, the sources that are requesting, enabled and not fast-class.
- R8: A source whose enable bit is clear affects neither output, no masked status word and no slot. Reading register 0x02 returns the unmasked input levels.
- R9: A slot is active only if its enable bit is set, its source index is below 32, and that source is enabled, requesting and not fast-class.
- R10: A configuration write presented in one cycle changes the outputs only after the next rising clock edge.
- R11: Synchronous active-high reset clears all enables, class bits, slot registers and the default address. Both outputs then read low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src_i | input | 32 | Level interrupt requests, one per source |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 6 | Word address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| fiq_o | output | 1 | Fast-interrupt request to the core |
| irq_o | output | 1 | Normal-interrupt request to the core |

## Verification
The hardest case to reach from the ports is a slot that looks active but must lose or be skipped. In that case a lower-numbered slot names a source that is disabled, fast-class or out of range, while a higher-numbered slot has a valid request. The stimulus programs three slots on purpose: slot 0 holds an invalid index, and two higher slots carry real sources. It then steps the source levels, the enables and the class bits one at a time and checks after each step which address register 0x05 returns.

// File: rtl/intr_vector_pkg.sv
package intr_vector_pkg;
  localparam int REG_AW = 6;
  localparam logic [REG_AW-1:0] REG_SRC_EN   = 6'h00;
  localparam logic [REG_AW-1:0] REG_FAST_SEL = 6'h01;
  localparam logic [REG_AW-1:0] REG_RAW      = 6'h02;
  localparam logic [REG_AW-1:0] REG_FAST_ST  = 6'h03;
  localparam logic [REG_AW-1:0] REG_NORM_ST  = 6'h04;
  localparam logic [REG_AW-1:0] REG_VEC_ADDR = 6'h05;
  localparam logic [REG_AW-1:0] REG_DEF_ADDR = 6'h06;
  localparam logic [1:0]        GRP_SLOTCTL  = 2'b01;
  localparam logic [1:0]        GRP_SLOTADR  = 2'b10;
  localparam int SLOT_EN_BIT = 7;
endpackage

// File: rtl/intr_cfg_regs.sv
module intr_cfg_regs
  import intr_vector_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int DW       = 32,
  localparam int SRC_FW  = $clog2(NUM_SRC) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [NUM_SRC-1:0] src_en,
  output logic [NUM_SRC-1:0] fast_sel,
  output logic [DW-1:0]     def_addr,
  output logic [NUM_SLOT-1:0] slot_on,
  output logic [SRC_FW-1:0] slot_src [NUM_SLOT],
  output logic [DW-1:0]     slot_addr [NUM_SLOT]
);
  localparam int SIW = $clog2(NUM_SLOT);

  logic [1:0]     grp;
  logic [SIW-1:0] sidx;
  assign grp  = addr[REG_AW-1:REG_AW-2];
  assign sidx = addr[SIW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      src_en   <= '0;
      fast_sel <= '0;
      def_addr <= '0;
      slot_on  <= '0;
      for (int k = 0; k < NUM_SLOT; k++) begin
        slot_src[k]  <= '0;
        slot_addr[k] <= '0;
      end
    end else if (we) begin
      if (addr == REG_SRC_EN)   src_en   <= wdata[NUM_SRC-1:0];
      if (addr == REG_FAST_SEL) fast_sel <= wdata[NUM_SRC-1:0];
      if (addr == REG_DEF_ADDR) def_addr <= wdata;
      if (grp == GRP_SLOTCTL) begin
        slot_on[sidx]  <= wdata[SLOT_EN_BIT];
        slot_src[sidx] <= wdata[SRC_FW-1:0];
      end
      if (grp == GRP_SLOTADR) slot_addr[sidx] <= wdata;
    end
  end

  assert_reset_clear_R11: assert property (@(posedge clk)
    rst |=> (src_en == '0 && fast_sel == '0 && slot_on == '0 && def_addr == '0));

  assert_cfg_write_R10: assert property (@(posedge clk) disable iff (rst)
    (we && addr == REG_SRC_EN) |=> (src_en == $past(wdata[NUM_SRC-1:0])));
endmodule

// File: rtl/intr_slot_arb.sv
module intr_slot_arb #(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int DW       = 32,
  localparam int SRC_FW  = $clog2(NUM_SRC) + 1,
  localparam int SIW     = $clog2(NUM_SLOT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  norm_pend,
  input  logic [NUM_SLOT-1:0] slot_on,
  input  logic [SRC_FW-1:0]   slot_src [NUM_SLOT],
  input  logic [DW-1:0]       slot_addr [NUM_SLOT],
  input  logic [DW-1:0]       def_addr,
  output logic [DW-1:0]       vec_addr,
  output logic                any_vec
);
  localparam logic [SRC_FW-1:0] SRC_LIMIT = SRC_FW'(NUM_SRC);

  logic [NUM_SLOT-1:0] active;
  logic [NUM_SLOT-1:0] win_1h;
  logic [SIW-1:0]      win_idx;

  for (genvar k = 0; k < NUM_SLOT; k++) begin : g_slot
    logic idx_ok;
    assign idx_ok    = slot_src[k] < SRC_LIMIT;
    assign active[k] = slot_on[k] && idx_ok &&
                       norm_pend[slot_src[k][SRC_FW-2:0]];
  end

  always_comb begin
    win_idx = '0;
    any_vec = 1'b0;
    for (int k = NUM_SLOT - 1; k >= 0; k--) begin
      if (active[k]) begin
        win_idx = SIW'(k);
        any_vec = 1'b1;
      end
    end
  end

  assign win_1h   = any_vec ? (NUM_SLOT'(1) << win_idx) : '0;
  assign vec_addr = any_vec ? slot_addr[win_idx] : def_addr;

  assert_win_onehot_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(win_1h));

  assert_win_lowest_R4: assert property (@(posedge clk) disable iff (rst)
    ((win_1h - NUM_SLOT'(1)) & active & {NUM_SLOT{any_vec}}) == '0);

  assert_win_is_active_R9: assert property (@(posedge clk) disable iff (rst)
    (win_1h & ~active) == '0);

  assert_default_addr_R6: assert property (@(posedge clk) disable iff (rst)
    (active == '0) |-> (vec_addr == def_addr));
endmodule

// File: rtl/intr_vector_ctrl.sv
module intr_vector_ctrl
  import intr_vector_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int NUM_SLOT = 16,
  parameter int DW       = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_src_i,
  input  logic               bus_we_i,
  input  logic [REG_AW-1:0]  bus_addr_i,
  input  logic [DW-1:0]      bus_wdata_i,
  output logic [DW-1:0]      bus_rdata_o,
  output logic               fiq_o,
  output logic               irq_o
);
  localparam int SRC_FW = $clog2(NUM_SRC) + 1;
  localparam int SIW    = $clog2(NUM_SLOT);

  logic [NUM_SRC-1:0]  src_en, fast_sel, fast_pend, norm_pend;
  logic [DW-1:0]       def_addr, vec_addr;
  logic [NUM_SLOT-1:0] slot_on;
  logic [SRC_FW-1:0]   slot_src [NUM_SLOT];
  logic [DW-1:0]       slot_addr [NUM_SLOT];
  logic                any_vec;

  intr_cfg_regs #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we_i), .addr(bus_addr_i), .wdata(bus_wdata_i),
    .src_en(src_en), .fast_sel(fast_sel), .def_addr(def_addr),
    .slot_on(slot_on), .slot_src(slot_src), .slot_addr(slot_addr)
  );

  assign fast_pend = irq_src_i & src_en & fast_sel;
  assign norm_pend = irq_src_i & src_en & ~fast_sel;
  assign fiq_o     = |fast_pend;
  assign irq_o     = |norm_pend;

  intr_slot_arb #(.NUM_SRC(NUM_SRC), .NUM_SLOT(NUM_SLOT), .DW(DW)) u_arb (
    .clk(clk), .rst(rst), .norm_pend(norm_pend), .slot_on(slot_on),
    .slot_src(slot_src), .slot_addr(slot_addr), .def_addr(def_addr),
    .vec_addr(vec_addr), .any_vec(any_vec)
  );

  logic [SIW-1:0] sidx;
  assign sidx = bus_addr_i[SIW-1:0];

  always_comb begin
    bus_rdata_o = '0;
    unique case (bus_addr_i[REG_AW-1:REG_AW-2])
      GRP_SLOTCTL: begin
        bus_rdata_o[SLOT_EN_BIT]  = slot_on[sidx];
        bus_rdata_o[SRC_FW-1:0]   = slot_src[sidx];
      end
      GRP_SLOTADR: bus_rdata_o = slot_addr[sidx];
      default: begin
        case (bus_addr_i)
          REG_SRC_EN:   bus_rdata_o[NUM_SRC-1:0] = src_en;
          REG_FAST_SEL: bus_rdata_o[NUM_SRC-1:0] = fast_sel;
          REG_RAW:      bus_rdata_o[NUM_SRC-1:0] = irq_src_i;
          REG_FAST_ST:  bus_rdata_o[NUM_SRC-1:0] = fast_pend;
          REG_NORM_ST:  bus_rdata_o[NUM_SRC-1:0] = norm_pend;
          REG_VEC_ADDR: bus_rdata_o = vec_addr;
          REG_DEF_ADDR: bus_rdata_o = def_addr;
          default:      bus_rdata_o = '0;
        endcase
      end
    endcase
  end

  assert_fiq_needs_src_R1: assert property (@(posedge clk) disable iff (rst)
    fiq_o |-> ((irq_src_i & src_en & fast_sel) != '0));

  assert_irq_needs_src_R5: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ((irq_src_i & src_en) != '0));

  assert_vec_implies_irq_R9: assert property (@(posedge clk) disable iff (rst)
    any_vec |-> irq_o);

  assert_disabled_silent_R8: assert property (@(posedge clk) disable iff (rst)
    (src_en == '0) |-> (!fiq_o && !irq_o));
endmodule

// File: tb/intr_vector_ctrl_bench.sv
module intr_vector_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] src;
  logic        we;
  logic [5:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        fiq, irq;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  intr_vector_ctrl u_intr_vector_ctrl (
    .clk(clk), .rst(rst), .irq_src_i(src), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .fiq_o(fiq), .irq_o(irq)
  );

  // enable, fast, sources, expected fiq, expected irq
  localparam int NV = 6;
  localparam logic [97:0] TBL [NV] = '{
    {32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 1'b0, 1'b0},
    {32'h0000_00F0, 32'h0000_0030, 32'h0000_0010, 1'b1, 1'b0},
    {32'h0000_00F0, 32'h0000_0030, 32'h0000_0040, 1'b0, 1'b1},
    {32'h8000_0001, 32'h8000_0000, 32'h8000_0001, 1'b1, 1'b1},
    {32'h0000_FFFF, 32'hFFFF_0000, 32'hFFFF_0000, 1'b0, 1'b0},
    {32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'h00FF_FF00, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst = 1'b1; src = '0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    src = 32'hFFFF_FFFF;
    #1;
    chk("R11 reset fiq", {31'd0, fiq}, 32'd0);
    chk("R11 reset irq", {31'd0, irq}, 32'd0);
    rst = 1'b0;
    rd(6'h05, r); chk("R11 reset vec", r, 32'd0);
    rd(6'h00, r); chk("R11 reset enable", r, 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [31:0] e, f, s;
      {e, f, s} = TBL[i][97:2];
      wr(6'h00, e);
      wr(6'h01, f);
      src = s;
      #1;
      chk("R1 fiq", {31'd0, fiq}, {31'd0, TBL[i][1]});
      chk("R5 irq", {31'd0, irq}, {31'd0, TBL[i][0]});
      rd(6'h03, r); chk("R2 fast status", r, s & e & f);
      rd(6'h04, r); chk("R7 normal status", r, s & e & ~f);
      rd(6'h02, r); chk("R8 raw", r, s);
    end

    // R8: disabled sources do nothing, raw still visible
    wr(6'h00, 32'h0); wr(6'h01, 32'h0);
    src = 32'h0000_1234; #1;
    chk("R8 disabled irq", {31'd0, irq}, 32'd0);
    rd(6'h02, r); chk("R8 raw disabled", r, 32'h0000_1234);
    rd(6'h04, r); chk("R8 norm masked", r, 32'd0);

    // slot programming
    wr(6'h06, 32'h0000_DEF0);
    wr(6'h13, 32'h80 | 32'd5);  wr(6'h23, 32'h0000_0300);
    wr(6'h17, 32'h80 | 32'd9);  wr(6'h27, 32'h0000_0700);
    wr(6'h10, 32'h80 | 32'd40); wr(6'h20, 32'h0000_0111);
    rd(6'h13, r); chk("R3 slot ctl readback", r, 32'h85);
    rd(6'h27, r); chk("R3 slot addr readback", r, 32'h700);
    wr(6'h00, 32'hFFFF_FFFF);

    src = 32'h0000_0200; #1;
    rd(6'h05, r); chk("R6 single slot", r, 32'h700);
    src = 32'h0000_0220; #1;
    rd(6'h05, r); chk("R4 lowest slot wins", r, 32'h300);
    src = 32'h0000_1000; #1;
    rd(6'h05, r); chk("R6 default addr", r, 32'hDEF0);
    chk("R5 non-vectored irq", {31'd0, irq}, 32'd1);
    src = 32'hFFFF_FDDF; #1;
    rd(6'h05, r); chk("R9 invalid index slot 0", r, 32'hDEF0);
    wr(6'h01, 32'h0000_0020);
    src = 32'h0000_0220; #1;
    rd(6'h05, r); chk("R9 fast source skipped", r, 32'h700);
    wr(6'h01, 32'h0); wr(6'h00, 32'hFFFF_FFDF); #1;
    rd(6'h05, r); chk("R8 disabled slot source", r, 32'h700);
    wr(6'h17, 32'h09); src = 32'h0000_0200; #1;
    rd(6'h05, r); chk("R9 slot enable off", r, 32'hDEF0);

    // R10: write takes effect only after the edge
    @(negedge clk);
    src = 32'h1; we = 1'b1; addr = 6'h01; wdata = 32'h1;
    #1 chk("R10 before edge fiq", {31'd0, fiq}, 32'd0);
    @(posedge clk); #1;
    chk("R10 after edge fiq", {31'd0, fiq}, 32'd1);
    @(negedge clk); we = 1'b0;

    // R11: reset mid run
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    src = 32'hFFFF_FFFF; #1;
    chk("R11 mid reset fiq", {31'd0, fiq}, 32'd0);
    chk("R11 mid reset irq", {31'd0, irq}, 32'd0);
    rd(6'h13, r); chk("R11 slot cleared", r, 32'd0);
    rd(6'h06, r); chk("R11 default cleared", r, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule